// File: doc/BRIEF.md
# Host Command Mailbox

This block is a small register file shared by a host processor and a processing core. The host sees twenty-one byte-wide locations at addresses 0 to 20. Addresses 0 to 3 are inbound slots that the host fills: slot 0 carries a command code, and slots 1 to 3 carry its arguments. Address 4 is a read-only flag word that shows which inbound slots still hold data the core has not read. Addresses 5 to 20 are sixteen outbound slots that the core fills for the host to read.

The host strobes are asynchronous to the core clock. Each strobe is passed through a two-flop synchronizer and an edge detector, so a strobe held for any number of core cycles acts exactly once. The address and write data must stay stable while the strobe is high. A command starts only when the host writes slot 0, so the arguments are written first. At that write the block latches the command code and the current value of slot 1, which serves as a host-chosen serial ID. It then raises a command-valid level towards the core. When the core acknowledges, outbound slot 0 takes the serial ID, or a fixed revision code when the command is the revision query. That write to outbound slot 0 raises the host interrupt, and a host read of address 5 clears it.

Top module: `hmb_mailbox`

## Requirements
- R1: After reset all inbound and outbound slots read 0, the flag word reads 0, and `host_irq` and `core_cmd_valid` are low.
- R2: A host write to address n (0 to 3) stores the byte in inbound slot n. The byte can be read back by the host at address n and by the core through `core_din` with `core_rd_idx` = n.
- R3: Bit n of the flag word (host address 4, bits 3:0) is set by a host write to inbound slot n and cleared when the core pulses `core_rd` with `core_rd_idx` = n. The upper bits read 0.
- R4: Host writes to addresses 1 to 3 leave `core_cmd_valid` low. A host write to address 0 sets `core_cmd_valid` and presents the written byte on `core_cmd_code`.
- R5: `core_cmd_valid` stays high until the core pulses `core_ack`, which clears it. A `core_ack` with no valid command changes nothing.
- R6: On an accepted `core_ack`, outbound slot 0 (host address 5) takes the value slot 1 held when the command was written. Later writes to slot 1 do not alter it.
- R7: When the latched command code is 0x0D, an accepted `core_ack` writes the revision code (default 0x5A) to outbound slot 0 instead of the serial ID.
- R8: `host_irq` rises on the cycle after outbound slot 0 is written, either by an accepted acknowledge or by a core write with `core_wr_idx` = 0. Only a host read strobe at address 5 clears it.
- R9: A core write with `core_wr_idx` = n stores `core_wdata` in outbound slot n, readable by the host at address 5+n. Writes to slots 1 to 15 leave `host_irq` unchanged.
- R10: Host writes to address 4 and to addresses 5 to 31 change no register. Host reads of addresses 21 to 31 return 0.
- R11: A host strobe takes effect on the third core clock edge after it rises. Held high for many cycles, it acts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 5 | Host register address, stable while a strobe is high |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Asynchronous host write strobe |
| host_rd | input | 1 | Asynchronous host read strobe, used only for interrupt clearing |
| host_rdata | output | 8 | Read data for `host_addr` |
| host_irq | output | 1 | Host interrupt, outbound slot 0 has new data |
| core_rd | input | 1 | Core read pulse for an inbound slot |
| core_rd_idx | input | 2 | Inbound slot the core reads |
| core_din | output | 8 | Contents of the inbound slot chosen by `core_rd_idx` |
| core_cmd_valid | output | 1 | A command is waiting for acknowledge |
| core_cmd_code | output | 8 | Latched command code |
| core_ack | input | 1 | Core accepts the pending command |
| core_wr | input | 1 | Core write pulse for an outbound slot |
| core_wr_idx | input | 4 | Outbound slot the core writes |
| core_wdata | input | 8 | Core write data |

## Verification
The command path is tried in three ways: with an ordinary code, with the revision code 0x0D, and with a slot-1 rewrite between command and acknowledge. Together these separate an echoed ID from a returned constant, and a latched ID from a live one. Argument-only writes, followed by selective core reads, show that each flag bit belongs to its own slot and that no command fires early. A long-held command strobe with an acknowledge inside it tells a single edge-detected event from a level-triggered one. Stray host writes to the flag word and outbound range, plus a read strobe on the wrong outbound slot, show what must not move.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

    localparam int HMB_DW = 8;

    typedef enum logic [1:0] {
        REG_DIN  = 2'd0,
        REG_STAT = 2'd1,
        REG_DOUT = 2'd2,
        REG_NONE = 2'd3
    } hmb_region_e;

    // Value placed in outbound slot 0 on acknowledge
    function automatic logic [HMB_DW-1:0] ack_value(
        input logic [HMB_DW-1:0] cmd,
        input logic [HMB_DW-1:0] sid,
        input logic [HMB_DW-1:0] rev_cmd,
        input logic [HMB_DW-1:0] rev_code
    );
        return (cmd == rev_cmd) ? rev_code : sid;
    endfunction

endpackage

// File: rtl/hmb_sync_edge.sv
module hmb_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/hmb_din_bank.sv
module hmb_din_bank
    import hmb_pkg::*;
#(
    parameter int N_DIN  = 4,
    parameter int DIN_IW = $clog2(N_DIN)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_evt,
    input  logic [DIN_IW-1:0]             wr_idx,
    input  logic [HMB_DW-1:0]             wr_data,
    input  logic                          rd_pulse,
    input  logic [DIN_IW-1:0]             rd_idx,
    output logic [N_DIN-1:0][HMB_DW-1:0]  din_q,
    output logic [N_DIN-1:0]              stat_q
);
    logic [N_DIN-1:0] wr_hit;
    logic [N_DIN-1:0] rd_hit;

    for (genvar i = 0; i < N_DIN; i++) begin : g_hit
        assign wr_hit[i] = wr_evt   && (wr_idx == DIN_IW'(i));
        assign rd_hit[i] = rd_pulse && (rd_idx == DIN_IW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q  <= '0;
            stat_q <= '0;
        end else begin
            for (int i = 0; i < N_DIN; i++) begin
                if (wr_hit[i]) begin
                    din_q[i]  <= wr_data;
                    stat_q[i] <= 1'b1;
                end else if (rd_hit[i]) begin
                    stat_q[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/hmb_dout_bank.sv
module hmb_dout_bank
    import hmb_pkg::*;
#(
    parameter int N_DOUT  = 16,
    parameter int DOUT_IW = $clog2(N_DOUT)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [DOUT_IW-1:0]             widx,
    input  logic [HMB_DW-1:0]              wdata,
    input  logic                           irq_clr,
    output logic [N_DOUT-1:0][HMB_DW-1:0]  dout_q,
    output logic                           irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (we) dout_q[widx] <= wdata;
            if (we && widx == '0) irq_q <= 1'b1;
            else if (irq_clr)     irq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/hmb_mailbox.sv
module hmb_mailbox
    import hmb_pkg::*;
#(
    parameter int                N_DIN       = 4,
    parameter int                N_DOUT      = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [HMB_DW-1:0] REV_CMD     = 8'h0D,
    parameter logic [HMB_DW-1:0] REV_CODE    = 8'h5A,
    parameter int                AW          = $clog2(N_DIN + 1 + N_DOUT),
    parameter int                DIN_IW      = $clog2(N_DIN),
    parameter int                DOUT_IW     = $clog2(N_DOUT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      host_addr,
    input  logic [HMB_DW-1:0]  host_wdata,
    input  logic               host_wr,
    input  logic               host_rd,
    output logic [HMB_DW-1:0]  host_rdata,
    output logic               host_irq,
    input  logic               core_rd,
    input  logic [DIN_IW-1:0]  core_rd_idx,
    output logic [HMB_DW-1:0]  core_din,
    output logic               core_cmd_valid,
    output logic [HMB_DW-1:0]  core_cmd_code,
    input  logic               core_ack,
    input  logic               core_wr,
    input  logic [DOUT_IW-1:0] core_wr_idx,
    input  logic [HMB_DW-1:0]  core_wdata
);
    localparam logic [AW-1:0] A_STAT  = AW'(N_DIN);
    localparam logic [AW-1:0] A_DOUT0 = AW'(N_DIN + 1);
    localparam logic [AW-1:0] A_END   = AW'(N_DIN + 1 + N_DOUT);

    logic wr_evt, rd_evt, cmd_evt, ack_fire;
    hmb_region_e           reg_kind;
    logic [DIN_IW-1:0]     din_idx;
    logic [DOUT_IW-1:0]    dout_idx;
    logic [N_DIN-1:0][HMB_DW-1:0]  din_q;
    logic [N_DIN-1:0]              stat_q;
    logic [N_DOUT-1:0][HMB_DW-1:0] dout_q;
    logic [HMB_DW-1:0]     cmd_q, sid_q;
    logic                  valid_q;
    logic                  do_we;
    logic [DOUT_IW-1:0]    do_idx;
    logic [HMB_DW-1:0]     do_data;

    hmb_sync_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .async_in(host_wr), .rise(wr_evt));
    hmb_sync_edge #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst(rst), .async_in(host_rd), .rise(rd_evt));

    // Address decode
    always_comb begin
        din_idx  = DIN_IW'(host_addr);
        dout_idx = DOUT_IW'(host_addr - A_DOUT0);
        if (host_addr < A_STAT)       reg_kind = REG_DIN;
        else if (host_addr == A_STAT) reg_kind = REG_STAT;
        else if (host_addr < A_END)   reg_kind = REG_DOUT;
        else                          reg_kind = REG_NONE;
    end

    assign cmd_evt  = wr_evt && (reg_kind == REG_DIN) && (din_idx == '0);
    assign ack_fire = core_ack && valid_q;

    hmb_din_bank #(.N_DIN(N_DIN), .DIN_IW(DIN_IW)) u_din (
        .clk(clk), .rst(rst),
        .wr_evt(wr_evt && reg_kind == REG_DIN), .wr_idx(din_idx),
        .wr_data(host_wdata),
        .rd_pulse(core_rd), .rd_idx(core_rd_idx),
        .din_q(din_q), .stat_q(stat_q));

    // Command latch: code and serial ID captured at the command write
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            sid_q   <= '0;
            valid_q <= 1'b0;
        end else if (cmd_evt) begin
            cmd_q   <= host_wdata;
            sid_q   <= din_q[1];
            valid_q <= 1'b1;
        end else if (ack_fire) begin
            valid_q <= 1'b0;
        end
    end

    // Acknowledge has priority over a core write in the same cycle
    always_comb begin
        do_we   = ack_fire || core_wr;
        do_idx  = ack_fire ? '0 : core_wr_idx;
        do_data = ack_fire ? ack_value(cmd_q, sid_q, REV_CMD, REV_CODE) : core_wdata;
    end

    hmb_dout_bank #(.N_DOUT(N_DOUT), .DOUT_IW(DOUT_IW)) u_dout (
        .clk(clk), .rst(rst),
        .we(do_we), .widx(do_idx), .wdata(do_data),
        .irq_clr(rd_evt && host_addr == A_DOUT0),
        .dout_q(dout_q), .irq_q(host_irq));

    always_comb begin
        case (reg_kind)
            REG_DIN:  host_rdata = din_q[din_idx];
            REG_STAT: host_rdata = {{(HMB_DW-N_DIN){1'b0}}, stat_q};
            REG_DOUT: host_rdata = dout_q[dout_idx];
            default:  host_rdata = '0;
        endcase
    end

    assign core_din       = din_q[core_rd_idx];
    assign core_cmd_valid = valid_q;
    assign core_cmd_code  = cmd_q;
endmodule

// File: rtl/hmb_mailbox_chk.sv
module hmb_mailbox_chk #(
    parameter int N_DIN   = 4,
    parameter int DOUT_IW = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               host_irq,
    input logic               core_cmd_valid,
    input logic               core_ack,
    input logic               core_wr,
    input logic [DOUT_IW-1:0] core_wr_idx,
    input logic               cmd_evt,
    input logic [N_DIN-1:0]   stat_q
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!host_irq && !core_cmd_valid && stat_q == '0));

    // R4
    valid_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_cmd_valid) |-> $past(cmd_evt));

    // R3
    cmd_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_evt |=> stat_q[0]);

    // R5
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (core_cmd_valid && !core_ack) |=> core_cmd_valid);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (core_cmd_valid && core_ack && !cmd_evt) |=> !core_cmd_valid);

    // R8
    ack_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (core_cmd_valid && core_ack) |=> host_irq);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_irq && !(core_cmd_valid && core_ack)
         && !(core_wr && core_wr_idx == '0)) |=> !host_irq);
endmodule

bind hmb_mailbox hmb_mailbox_chk #(.N_DIN(N_DIN), .DOUT_IW(DOUT_IW)) u_chk (
    .clk(clk), .rst(rst), .host_irq(host_irq),
    .core_cmd_valid(core_cmd_valid), .core_ack(core_ack),
    .core_wr(core_wr), .core_wr_idx(core_wr_idx),
    .cmd_evt(cmd_evt), .stat_q(stat_q));

// File: tb/hmb_mailbox_tb.sv
module hmb_mailbox_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       host_irq;
    logic       core_rd = 1'b0;
    logic [1:0] core_rd_idx = '0;
    logic [7:0] core_din;
    logic       core_cmd_valid;
    logic [7:0] core_cmd_code;
    logic       core_ack = 1'b0;
    logic       core_wr = 1'b0;
    logic [3:0] core_wr_idx = '0;
    logic [7:0] core_wdata = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hmb_mailbox u_dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        repeat (4) @(negedge clk);
        host_wr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_rd_strobe(input logic [4:0] a);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        repeat (4) @(negedge clk);
        host_rd = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic core_read(input logic [1:0] i);
        @(negedge clk); core_rd = 1'b1; core_rd_idx = i;
        @(negedge clk); core_rd = 1'b0;
    endtask

    task automatic core_write(input logic [3:0] i, input logic [7:0] d);
        @(negedge clk); core_wr = 1'b1; core_wr_idx = i; core_wdata = d;
        @(negedge clk); core_wr = 1'b0;
    endtask

    task automatic core_acknowledge();
        @(negedge clk); core_ack = 1'b1;
        @(negedge clk); core_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic [7:0] acc = '0;
        for (int a = 0; a < 21; a++) begin
            peek(5'(a), d);
            acc |= d;
        end
        check("R1 all registers zero", acc, 8'h00);
        check("R1 irq low", {7'd0, host_irq}, 8'h00);
        check("R1 cmd_valid low", {7'd0, core_cmd_valid}, 8'h00);
    endtask

    task automatic t_params();
        logic [7:0] d;
        host_write(5'd1, 8'h3C);
        host_write(5'd2, 8'h55);
        host_write(5'd3, 8'h77);
        peek(5'd2, d); check("R2 host readback slot2", d, 8'h55);
        peek(5'd3, d); check("R2 host readback slot3", d, 8'h77);
        @(negedge clk); core_rd_idx = 2'd1;
        #1 check("R2 core_din slot1", core_din, 8'h3C);
        peek(5'd4, d); check("R3 flags after param writes", d, 8'h0E);
        check("R4 no command from params", {7'd0, core_cmd_valid}, 8'h00);
        core_read(2'd2);
        peek(5'd4, d); check("R3 flag2 cleared by core read", d, 8'h0A);
    endtask

    task automatic t_command();
        logic [7:0] d;
        host_write(5'd0, 8'h21);
        check("R4 cmd_valid after slot0 write", {7'd0, core_cmd_valid}, 8'h01);
        check("R4 command code", core_cmd_code, 8'h21);
        peek(5'd4, d); check("R3 flag0 set", d, 8'h0B);
        host_write(5'd1, 8'h99);
        check("R5 valid held without ack", {7'd0, core_cmd_valid}, 8'h01);
        core_acknowledge();
        check("R5 ack clears valid", {7'd0, core_cmd_valid}, 8'h00);
        peek(5'd5, d); check("R6 latched serial ID", d, 8'h3C);
        check("R8 irq after ack", {7'd0, host_irq}, 8'h01);
        host_rd_strobe(5'd5);
        check("R8 irq cleared by read", {7'd0, host_irq}, 8'h00);
    endtask

    task automatic t_revision();
        logic [7:0] d;
        host_write(5'd1, 8'h11);
        host_write(5'd0, 8'h0D);
        core_acknowledge();
        peek(5'd5, d); check("R7 revision code", d, 8'h5A);
        host_rd_strobe(5'd5);
    endtask

    task automatic t_idle_ack();
        logic [7:0] d;
        core_acknowledge();
        repeat (2) @(negedge clk);
        peek(5'd5, d); check("R5 idle ack leaves slot0", d, 8'h5A);
        check("R5 idle ack no irq", {7'd0, host_irq}, 8'h00);
    endtask

    task automatic t_core_out();
        logic [7:0] d;
        core_write(4'd7, 8'hC3);
        core_write(4'd15, 8'h6E);
        peek(5'd12, d); check("R9 slot7 at addr12", d, 8'hC3);
        peek(5'd20, d); check("R9 slot15 at addr20", d, 8'h6E);
        check("R9 no irq for slots 1-15", {7'd0, host_irq}, 8'h00);
        core_write(4'd0, 8'h42);
        check("R8 irq on core slot0 write", {7'd0, host_irq}, 8'h01);
        host_rd_strobe(5'd6);
        check("R8 other read keeps irq", {7'd0, host_irq}, 8'h01);
        host_rd_strobe(5'd5);
        check("R8 addr5 read clears irq", {7'd0, host_irq}, 8'h00);
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        peek(5'd4, d);
        host_write(5'd4, 8'hFF);
        begin
            logic [7:0] d2;
            peek(5'd4, d2); check("R10 flag word not writable", d2, d);
        end
        host_write(5'd12, 8'h00);
        peek(5'd12, d); check("R10 outbound not host writable", d, 8'hC3);
        host_write(5'd25, 8'hAB);
        peek(5'd25, d); check("R10 unmapped reads zero", d, 8'h00);
    endtask

    task automatic t_strobe_timing();
        @(negedge clk);
        host_addr = 5'd0; host_wdata = 8'h33; host_wr = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 no effect after two edges", {7'd0, core_cmd_valid}, 8'h00);
        @(negedge clk);
        check("R11 effect on third edge", {7'd0, core_cmd_valid}, 8'h01);
        core_acknowledge();
        repeat (4) @(negedge clk);
        check("R11 held strobe acts once", {7'd0, core_cmd_valid}, 8'h00);
        host_wr = 1'b0;
        repeat (4) @(negedge clk);
        host_rd_strobe(5'd5);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_params();
        t_command();
        t_revision();
        t_idle_ack();
        t_core_out();
        t_ignored();
        t_strobe_timing();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule